// File: doc/BRIEF.md
# Redundant Read-Retry Table Majority Decoder

This block turns the raw byte stream taken from a flash device's one-time-programmable read-retry area into a clean table of retry settings. The area is written with every item repeated eight times, so that a few bad bytes do not lose the table. The payload part also holds a second, bit-inverted set of those copies. The block stores the incoming stream in a local buffer. It first votes out the mode count and the register count. It then votes out every table entry, one at a time, and writes each result to a table write port.

If the plain copies of an entry do not produce a winner, the block votes again over the inverted copies and stores the bit-inverted winner. Any vote that cannot be resolved, or a stream too short to hold the table its header describes, ends the decode with an error. A one-cycle done pulse marks the end of every decode, whether it succeeded or failed.

Top module: `otp_rr_decoder`

## Requirements
- R1: A stream is a run of bytes with in_valid_i high and ends with a byte that has in_last_i high. Its first 8 bytes are copies of the mode count and the next 8 bytes are copies of the register count. The voted values appear on mode_cnt_o and reg_cnt_o.
- R2: A vote over 8 copies considers only the candidates at copy positions 0 to 3, in ascending order. A candidate wins when more than 4 of the copies at higher positions equal it. The first winner is the result.
- R3: If no candidate wins the mode count vote or the register count vote, the decode ends with err_o high and no table writes.
- R4: Let S = modes*regs. Copy k (0..7) of entry idx = m*regs + r is read from byte 16 + (2k+p)*S + idx. Here p=0 selects the plain copies and p=1 selects the inverted copies.
- R5: If the plain vote for an entry fails, the block votes over the inverted copies. It writes the bitwise complement of that winner.
- R6: Entries are written with one tbl_we_o cycle each, in ascending idx order from 0 to S-1. This is mode-major order. tbl_idx_o carries idx and tbl_val_o carries the value.
- R7: If both votes for an entry fail, the decode ends with err_o high. All entries before it have been written, and no entry from it onward is written.
- R8: A stream shorter than 16 bytes, or shorter than 16 + 16*S bytes, ends with err_o high and no table writes. A stream of exactly 16 + 16*S bytes is accepted.
- R9: done_o is high for exactly one cycle per decode. That cycle is the one after the final table write, or comes after the failing step. err_o is valid in that cycle and holds until the first byte of the next stream.
- R10: When S is 0, the decode finishes without error and makes no table writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Stream byte valid; accepted only while idle |
| in_byte_i | input | 8 | Stream byte |
| in_last_i | input | 1 | Marks the final byte of the stream |
| mode_cnt_o | output | 8 | Voted mode count |
| reg_cnt_o | output | 8 | Voted register count |
| tbl_we_o | output | 1 | Table write strobe |
| tbl_idx_o | output | 16 | Table index m*regs + r |
| tbl_val_o | output | 8 | Decoded table value |
| done_o | output | 1 | One-cycle end-of-decode pulse |
| err_o | output | 1 | Decode failed; held until the next stream |

## Verification
Clean streams are swept over every shape from 1x1 to 3x3. The same shapes are then run with the plain copies of alternate entries spoiled, which separates the plain path from the inverted fallback and exposes any wrong inversion or wrong offset. Count headers with the bad copies at positions 0, 0-1 and 0-2, and one header whose last five copies agree, show the asymmetric candidate scan at work. A symmetric majority would accept that last header. Streams cut short by one byte, a stream that ends inside the header, an entry with both copy sets spoiled, and a zero-size table mark the error and empty-table boundaries.

// File: rtl/otp_dec_pkg.sv
package otp_dec_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_GATH, ST_VOTE, ST_CHK, ST_FIN} st_e;
  typedef enum logic [1:0] {IT_MODES, IT_REGS, IT_VAL} item_e;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned IDX_W  = 16;
  localparam int unsigned ADR_W  = 24;
endpackage

// File: rtl/otp_stream_buf.sv
module otp_stream_buf #(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/otp_vote.sv
module otp_vote #(
  parameter int unsigned COPIES = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   chk_i,
  input  logic [COPIES-1:0][7:0] copies_i,
  output logic                   win_o,
  output logic [7:0]             val_o
);
  localparam int unsigned HALF = COPIES / 2;

  // scan only the lower half; count matches at higher positions
  always_comb begin
    win_o = 1'b0;
    val_o = '0;
    for (int i = 0; i < HALF; i++) begin
      int cnt;
      cnt = 0;
      for (int j = i + 1; j < COPIES; j++)
        if (copies_i[j] == copies_i[i]) cnt++;
      if (!win_o && cnt > HALF) begin
        win_o = 1'b1;
        val_o = copies_i[i];
      end
    end
  end

  logic [COPIES-1:0] eq;
  always_comb
    for (int j = 0; j < COPIES; j++) eq[j] = (copies_i[j] == val_o);

  // a winner must be backed by at least HALF+2 copies in total
  assert_win_support_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_i && win_o) |-> ($countones(eq) >= HALF + 2));
endmodule

// File: rtl/otp_addr.sv
module otp_addr
  import otp_dec_pkg::*;
#(
  parameter int unsigned COPIES = 8,
  localparam int unsigned KW = $clog2(COPIES)
) (
  input  item_e             item_i,
  input  logic [KW-1:0]     k_i,
  input  logic              inv_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [IDX_W-1:0]  set_i,
  output logic [ADR_W-1:0]  addr_o
);
  logic [ADR_W-1:0] set_w, k_w;
  assign set_w = ADR_W'(set_i);
  assign k_w   = ADR_W'(k_i);

  always_comb begin
    unique case (item_i)
      IT_MODES: addr_o = k_w;
      IT_REGS:  addr_o = ADR_W'(COPIES) + k_w;
      default:  addr_o = ADR_W'(2 * COPIES) + (inv_i ? set_w : '0)
                         + ADR_W'(idx_i) + ((k_w << 1) * set_w);
    endcase
  end
endmodule

// File: rtl/otp_rr_decoder.sv
module otp_rr_decoder
  import otp_dec_pkg::*;
#(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned COPIES = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        in_valid_i,
  input  logic [7:0]  in_byte_i,
  input  logic        in_last_i,
  output logic [7:0]  mode_cnt_o,
  output logic [7:0]  reg_cnt_o,
  output logic        tbl_we_o,
  output logic [15:0] tbl_idx_o,
  output logic [7:0]  tbl_val_o,
  output logic        done_o,
  output logic        err_o
);
  localparam int unsigned AW  = $clog2(DEPTH);
  localparam int unsigned LW  = $clog2(DEPTH + 1);
  localparam int unsigned KW  = $clog2(COPIES);
  localparam int unsigned HDR = 2 * COPIES;

  st_e   state_q;
  item_e item_q;
  logic [LW-1:0]    wptr_q, len_nx;
  logic [KW-1:0]    k_q;
  logic             inv_q, err_q, done_q, we_q;
  logic [IDX_W-1:0] idx_q, set_w, tidx_q;
  logic [7:0]       modes_q, regs_q, tval_q, rd_w, vval_w;
  logic [COPIES-1:0][7:0] copies_q;
  logic [ADR_W-1:0] addr_w, need_w;
  logic             vwin_w, accept_w, wr_w;

  assign accept_w = (state_q == ST_IDLE) && in_valid_i;
  assign wr_w     = accept_w && (wptr_q < LW'(DEPTH));
  assign len_nx   = wptr_q + LW'(wr_w);
  assign set_w    = IDX_W'(modes_q) * IDX_W'(regs_q);
  assign need_w   = ADR_W'(HDR) + ADR_W'(set_w) * ADR_W'(2 * COPIES);

  otp_stream_buf #(.DEPTH(DEPTH)) u_buf (
    .clk_i(clk_i), .we_i(wr_w), .waddr_i(AW'(wptr_q)), .wdata_i(in_byte_i),
    .raddr_i(AW'(addr_w)), .rdata_o(rd_w));

  otp_addr #(.COPIES(COPIES)) u_addr (
    .item_i(item_q), .k_i(k_q), .inv_i(inv_q), .idx_i(idx_q),
    .set_i(set_w), .addr_o(addr_w));

  otp_vote #(.COPIES(COPIES)) u_vote (
    .clk_i(clk_i), .rst_ni(rst_ni), .chk_i(state_q == ST_VOTE),
    .copies_i(copies_q), .win_o(vwin_w), .val_o(vval_w));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      item_q   <= IT_MODES;
      wptr_q   <= '0;
      k_q      <= '0;
      inv_q    <= 1'b0;
      err_q    <= 1'b0;
      done_q   <= 1'b0;
      we_q     <= 1'b0;
      idx_q    <= '0;
      tidx_q   <= '0;
      tval_q   <= '0;
      modes_q  <= '0;
      regs_q   <= '0;
      copies_q <= '0;
    end else begin
      done_q <= 1'b0;
      we_q   <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept_w) begin
          if (wptr_q == '0) err_q <= 1'b0;
          wptr_q <= len_nx;
          if (in_last_i) begin
            k_q    <= '0;
            item_q <= IT_MODES;
            if (len_nx < LW'(HDR)) begin
              err_q   <= 1'b1;
              state_q <= ST_FIN;
            end else state_q <= ST_GATH;
          end
        end
        ST_GATH: begin
          copies_q[k_q] <= rd_w;
          if (k_q == KW'(COPIES - 1)) state_q <= ST_VOTE;
          else k_q <= k_q + 1'b1;
        end
        ST_VOTE: begin
          k_q <= '0;
          unique case (item_q)
            IT_MODES: if (vwin_w) begin
              modes_q <= vval_w;
              item_q  <= IT_REGS;
              state_q <= ST_GATH;
            end else begin
              err_q   <= 1'b1;
              state_q <= ST_FIN;
            end
            IT_REGS: if (vwin_w) begin
              regs_q  <= vval_w;
              state_q <= ST_CHK;
            end else begin
              err_q   <= 1'b1;
              state_q <= ST_FIN;
            end
            default: if (vwin_w) begin
              we_q   <= 1'b1;
              tidx_q <= idx_q;
              tval_q <= inv_q ? ~vval_w : vval_w;
              inv_q  <= 1'b0;
              if (idx_q == set_w - 1'b1) state_q <= ST_FIN;
              else begin
                idx_q   <= idx_q + 1'b1;
                state_q <= ST_GATH;
              end
            end else if (!inv_q) begin
              inv_q   <= 1'b1;
              state_q <= ST_GATH;
            end else begin
              err_q   <= 1'b1;
              state_q <= ST_FIN;
            end
          endcase
        end
        ST_CHK: begin
          idx_q  <= '0;
          inv_q  <= 1'b0;
          item_q <= IT_VAL;
          if (need_w > ADR_W'(wptr_q)) begin
            err_q   <= 1'b1;
            state_q <= ST_FIN;
          end else if (set_w == '0) state_q <= ST_FIN;
          else state_q <= ST_GATH;
        end
        default: begin
          done_q  <= 1'b1;
          wptr_q  <= '0;
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign mode_cnt_o = modes_q;
  assign reg_cnt_o  = regs_q;
  assign tbl_we_o   = we_q;
  assign tbl_idx_o  = tidx_q;
  assign tbl_val_o  = tval_q;
  assign done_o     = done_q;
  assign err_o      = err_q;

  assert_rd_in_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_GATH) |-> (addr_w < ADR_W'(wptr_q)));
  assert_we_idx_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbl_we_o |-> (tbl_idx_o < set_w));
  assert_no_we_on_err_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !tbl_we_o);
  assert_short_err_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CHK && need_w > ADR_W'(wptr_q)) |=> (err_o && state_q == ST_FIN));
  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: tb/otp_rr_decoder_tb.sv
`timescale 1ns/100ps
module otp_rr_decoder_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_byte = '0;
  logic [7:0] mode_cnt, reg_cnt, tbl_val;
  logic tbl_we, done, err;
  logic [15:0] tbl_idx;

  always #2.5 clk = ~clk;

  otp_rr_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_byte_i(in_byte),
    .in_last_i(in_last), .mode_cnt_o(mode_cnt), .reg_cnt_o(reg_cnt),
    .tbl_we_o(tbl_we), .tbl_idx_o(tbl_idx), .tbl_val_o(tbl_val),
    .done_o(done), .err_o(err));

  int n_tests = 0, n_fail = 0;
  logic [7:0] sbuf [0:255];
  logic [15:0] plain_bad;
  int both_bad;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic logic [7:0] vfun(input int idx);
    return 8'((idx * 37 + 90) ^ 8'hA5);
  endfunction

  // R4 layout: copy k of entry idx at 16 + (2k+p)*S + idx
  task automatic build(input int m, input int r);
    int s;
    s = m * r;
    for (int i = 0; i < 256; i++) sbuf[i] = 8'h00;
    for (int k = 0; k < 8; k++) begin
      sbuf[k] = 8'(m);
      sbuf[8 + k] = 8'(r);
    end
    for (int idx = 0; idx < s; idx++)
      for (int k = 0; k < 8; k++) begin
        sbuf[16 + 2 * k * s + idx] = (k < 3 && plain_bad[idx]) ?
          (vfun(idx) ^ 8'(8'h11 * (k + 1))) : vfun(idx);
        sbuf[16 + (2 * k + 1) * s + idx] = (k < 3 && idx == both_bad) ?
          (~vfun(idx) ^ 8'(8'h11 * (k + 1))) : ~vfun(idx);
      end
  endtask

  task automatic run(input int n, input bit exp_err, input int exp_nw,
                     input int exp_m, input int exp_r, input string rq);
    int nw, cyc;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_byte = sbuf[i]; in_last = (i == n - 1);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    nw = 0; cyc = 0;
    while (!done && cyc < 5000) begin
      if (tbl_we) begin
        chk(int'(tbl_idx) == nw, {rq, " R6 idx order"}, tbl_idx, nw);
        chk(tbl_val == vfun(nw), {rq, " R5 value"}, tbl_val, vfun(nw));
        nw++;
      end
      @(negedge clk);
      cyc++;
    end
    chk(cyc < 5000, {rq, " R9 done seen"}, cyc, 0);
    chk(err == exp_err, {rq, " err at done"}, err, exp_err);
    chk(nw == exp_nw, {rq, " write count"}, nw, exp_nw);
    if (!exp_err) begin
      chk(mode_cnt == 8'(exp_m), {rq, " R1 modes"}, mode_cnt, exp_m);
      chk(reg_cnt == 8'(exp_r), {rq, " R1 regs"}, reg_cnt, exp_r);
    end
    @(negedge clk);
    chk(!done, {rq, " R9 one-cycle done"}, done, 0);
    chk(err == exp_err, {rq, " R9 err held"}, err, exp_err);
  endtask

  initial begin
    plain_bad = '0; both_bad = -1;
    repeat (3) @(negedge clk);
    chk(!done && !tbl_we && !err, "R9 reset state", {done, tbl_we, err}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // sweep of shapes, clean and with fallback on alternate entries
    for (int m = 1; m <= 3; m++)
      for (int r = 1; r <= 3; r++) begin
        plain_bad = '0;
        build(m, r);
        run(16 + 16 * m * r, 1'b0, m * r, m, r, "R4 clean sweep");
        plain_bad = 16'h5555;
        build(m, r);
        run(16 + 16 * m * r, 1'b0, m * r, m, r, "R5 fallback sweep");
      end
    plain_bad = '0;

    // R2: bad copy 0 -> candidate 1 wins
    build(2, 3); sbuf[0] = 8'd9;
    run(112, 1'b0, 6, 2, 3, "R2 bad copy0");
    // R2: bad copies 0,1 -> candidate 2 wins
    build(2, 3); sbuf[8] = 8'd9; sbuf[9] = 8'd10;
    run(112, 1'b0, 6, 2, 3, "R2 bad copy0-1");
    // R3: bad copies 0..2 -> no winner
    build(2, 3); sbuf[0] = 8'd9; sbuf[1] = 8'd10; sbuf[2] = 8'd11;
    run(112, 1'b1, 0, 0, 0, "R3 mode vote fail");
    // R2/R3: five equal trailing copies still lose (asymmetric rule)
    build(2, 3);
    for (int k = 3; k < 8; k++) sbuf[8 + k] = 8'd5;
    run(112, 1'b1, 0, 0, 0, "R3 trailing five lose");
    // R7: both copy sets of entry 2 spoiled
    plain_bad = 16'h0004; both_bad = 2;
    build(2, 3);
    run(112, 1'b1, 2, 0, 0, "R7 both fail");
    plain_bad = '0; both_bad = -1;
    // R8: one byte short, then header-only truncation
    build(2, 3);
    run(111, 1'b1, 0, 0, 0, "R8 short by one");
    build(2, 3);
    run(10, 1'b1, 0, 0, 0, "R8 short header");
    // R9: error cleared by next stream; R10 empty table
    build(0, 3);
    run(16, 1'b0, 0, 0, 3, "R10 empty table");
    build(3, 0);
    run(16, 1'b0, 0, 3, 0, "R10 zero regs");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule